// File: doc/BRIEF.md
# NAND Bus Phase Timing Sequencer

This block turns single host requests into cycles on an asynchronous NAND flash bus that is 8 or 16 bits wide. The host picks one of three targets for each request: a command byte, an address byte or data. Every bus cycle the block produces has the same shape. There is an optional setup phase with chip enable low, then a strobe phase in which WE# or RE# is low, then a hold phase with the strobe released, and finally an optional release phase with the data drivers off. The length of each phase in clock cycles comes from a timing word. A data read that directly follows a command or an address write gets an extra wait, so that the flash sees the required latch-to-read-enable spacing.

A 32-bit data request is split into several bus beats, least significant part first. Read data is collected into one host word. The host sees a single ready line. A request is taken on the clock edge where both the request and ready are high. Ready then stays low until the last release phase has ended. The configuration words are plain inputs and are held stable by the surrounding logic.

Top module: `nand_phase_seq`

## Requirements
- R1: During and after reset with no request: ce_n=1, cle=0, ale=0, we_n=1, re_n=1, dq_oe=0, host_rdy=1.
- R2: A request is accepted on a rising edge where host_req and host_rdy are both 1. host_rdy is 0 from the next cycle until the last release phase of that access has ended. A host_req raised while host_rdy is 0 has no effect.
- R3: Each beat runs these phases in order: setup for timing[7:0] cycles with CE asserted, strobe for timing[15:8] cycles, hold for timing[23:16] cycles, then release for timing[31:24] cycles. In the release phase CE, CLE, ALE and dq_oe are all inactive.
- R4: A strobe or hold count of zero lasts one cycle. A setup or release count of zero skips that phase.
- R5: Target encoding: host_tgt 2'b00 = command, which raises CLE in setup, strobe and hold; 2'b01 = address, which raises ALE in the same phases; 2'b1x = data. Command and address accesses are always one byte write of host_wdata[7:0] on dq[7:0], whatever host_we says.
- R6: A write beat drives dq_oe in setup, strobe and hold, and pulls we_n low only during the strobe.
- R7: A read beat pulls re_n low only during the strobe. nand_dq_in is captured on the edge where re_n rises. The assembled word appears on host_rdata once host_rdy returns.
- R8: When host_word=1, a data access is split into four byte beats on an 8-bit bus (ctrl[4]=0), using host bits [7:0] first, or into two 16-bit beats on a 16-bit bus, using [15:0] first. When host_word=0, it is one beat on dq[7:0], and a read returns {24'h0, byte}.
- R9: A data read that follows a command access starts with ctrl[12:9] cycles of wait. One that follows an address access starts with ctrl[16:13] cycles. In this wait CE is asserted and everything else is idle. A read after a data access has no wait.
- R10: When ctrl[2]=0, ce_n is held at 1. Access timing and the other outputs are unaffected, including for an access already under way.
- R11: Control bits other than 2, 4 and 16:9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 32 | Control word: bank enable, bus width, read waits |
| cfg_timing | input | 32 | Phase lengths: setup, strobe, hold, release |
| host_req | input | 1 | Access request |
| host_tgt | input | 2 | Access target: command, address or data |
| host_we | input | 1 | 1 = data write, 0 = data read |
| host_word | input | 1 | 1 = 32-bit data access, 0 = single byte |
| host_wdata | input | 32 | Write data, or the command/address byte |
| host_rdy | output | 1 | Idle and able to accept |
| host_rdata | output | 32 | Assembled read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Bus data out |
| nand_dq_oe | output | 1 | Bus data output enable |
| nand_dq_in | input | 16 | Bus data in |

## Verification
The assertions assume that cfg_timing and the width bit only change while host_rdy is high. Phase lengths are read live, so changing them mid-access would break the strobe and hold relations the assertions check. The stimulus changes configuration only in idle cycles. The one exception is the bank enable bit, which it toggles inside an access on purpose. Requests made while busy are driven deliberately, to show they are ignored, and are withdrawn before the block becomes ready again.

// File: rtl/nand_phase_seq.sv
module nand_phase_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_ctrl,
  input  logic [31:0] cfg_timing,
  input  logic        host_req,
  input  logic [1:0]  host_tgt,
  input  logic        host_we,
  input  logic        host_word,
  input  logic [31:0] host_wdata,
  output logic        host_rdy,
  output logic [31:0] host_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [15:0] nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [15:0] nand_dq_in
);

  typedef enum logic [2:0] {S_IDLE, S_DLY, S_SET, S_STB, S_HLD, S_HIZ} st_t;
  localparam logic [1:0] P_NONE = 2'd0, P_CMD = 2'd1, P_ADDR = 2'd2;

  st_t        st, first_st;
  logic [7:0] cnt, first_cnt;
  logic [7:0] t_set, t_stb, t_hld, t_hiz;
  logic [1:0] tgt, beat, nlast, prev;
  logic       wr, word, w16, last;
  logic [31:0] wdat, rdat, wsh8, wsh16;
  logic [3:0] rd_dly;
  logic       act, bus16, bank_en;
  logic       unused_ok;

  assign bus16   = cfg_ctrl[4];
  assign bank_en = cfg_ctrl[2];
  assign unused_ok = ^{cfg_ctrl[31:17], cfg_ctrl[8:5], cfg_ctrl[3], cfg_ctrl[1:0]};

  assign t_set = cfg_timing[7:0];
  assign t_stb = (cfg_timing[15:8]  == 8'd0) ? 8'd1 : cfg_timing[15:8];
  assign t_hld = (cfg_timing[23:16] == 8'd0) ? 8'd1 : cfg_timing[23:16];
  assign t_hiz = cfg_timing[31:24];

  assign first_st  = (t_set != 8'd0) ? S_SET : S_STB;
  assign first_cnt = (t_set != 8'd0) ? t_set - 8'd1 : t_stb - 8'd1;
  assign last      = (beat == nlast);

  always_comb begin
    rd_dly = 4'd0;
    if (host_tgt[1] && !host_we) begin
      if (prev == P_CMD)       rd_dly = cfg_ctrl[12:9];
      else if (prev == P_ADDR) rd_dly = cfg_ctrl[16:13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= 8'd0;
      tgt   <= 2'd0;
      wr    <= 1'b1;
      word  <= 1'b0;
      w16   <= 1'b0;
      wdat  <= 32'd0;
      rdat  <= 32'd0;
      beat  <= 2'd0;
      nlast <= 2'd0;
      prev  <= P_NONE;
    end else begin
      case (st)
        S_IDLE: if (host_req) begin
          tgt   <= host_tgt;
          wr    <= !host_tgt[1] || host_we;
          word  <= host_tgt[1] && host_word;
          w16   <= bus16;
          wdat  <= host_wdata;
          beat  <= 2'd0;
          nlast <= (host_tgt[1] && host_word) ? (bus16 ? 2'd1 : 2'd3) : 2'd0;
          prev  <= host_tgt[1] ? P_NONE : (host_tgt[0] ? P_ADDR : P_CMD);
          if (rd_dly != 4'd0) begin
            st  <= S_DLY;
            cnt <= {4'd0, rd_dly} - 8'd1;
          end else begin
            st  <= first_st;
            cnt <= first_cnt;
          end
        end
        default: begin
          if (cnt != 8'd0) cnt <= cnt - 8'd1;
          else begin
            case (st)
              S_DLY: begin
                st  <= first_st;
                cnt <= first_cnt;
              end
              S_SET: begin
                st  <= S_STB;
                cnt <= t_stb - 8'd1;
              end
              S_STB: begin
                st  <= S_HLD;
                cnt <= t_hld - 8'd1;
                if (!wr) begin
                  if (!word)    rdat <= {24'd0, nand_dq_in[7:0]};
                  else if (w16) rdat[{beat[0], 4'b0000} +: 16] <= nand_dq_in;
                  else          rdat[{beat, 3'b000} +: 8] <= nand_dq_in[7:0];
                end
              end
              S_HLD: begin
                if (t_hiz != 8'd0) begin
                  st  <= S_HIZ;
                  cnt <= t_hiz - 8'd1;
                end else if (last) st <= S_IDLE;
                else begin
                  beat <= beat + 2'd1;
                  st   <= first_st;
                  cnt  <= first_cnt;
                end
              end
              S_HIZ: begin
                if (last) st <= S_IDLE;
                else begin
                  beat <= beat + 2'd1;
                  st   <= first_st;
                  cnt  <= first_cnt;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign wsh8  = wdat >> {beat, 3'b000};
  assign wsh16 = wdat >> {beat[0], 4'b0000};

  always_comb begin
    if (!word)    nand_dq_out = {8'd0, wdat[7:0]};
    else if (w16) nand_dq_out = wsh16[15:0];
    else          nand_dq_out = {8'd0, wsh8[7:0]};
  end

  assign act        = (st == S_SET) || (st == S_STB) || (st == S_HLD);
  assign nand_ce_n  = !((act || st == S_DLY) && bank_en);
  assign nand_cle   = act && (tgt == 2'b00);
  assign nand_ale   = act && (tgt == 2'b01);
  assign nand_we_n  = !((st == S_STB) && wr);
  assign nand_re_n  = !((st == S_STB) && !wr);
  assign nand_dq_oe = act && wr;
  assign host_rdy   = (st == S_IDLE);
  assign host_rdata = rdat;

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale));
  assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_hold_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> nand_dq_oe);
  assert_hold_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> !host_rdy);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdy && host_req) |=> !host_rdy);

endmodule

// File: tb/test_nand_phase_seq.sv
`timescale 1ns/1ps
module test_nand_phase_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ctrl, cfg_timing;
  logic        host_req = 1'b0;
  logic [1:0]  host_tgt = 2'b00;
  logic        host_we = 1'b0, host_word = 1'b0;
  logic [31:0] host_wdata = 32'd0;
  logic        host_rdy;
  logic [31:0] host_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in = 16'hDEAD;

  nand_phase_seq i_nand_phase_seq (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_timing(cfg_timing),
    .host_req(host_req), .host_tgt(host_tgt), .host_we(host_we), .host_word(host_word),
    .host_wdata(host_wdata), .host_rdy(host_rdy), .host_rdata(host_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic ce_on, cle, ale, we_n, re_n, oe;
    logic [15:0] dq, din;
  } ent_t;

  ent_t        q[$];
  int          vectors = 0, errors = 0, seqno = 0, prev_m = 0;
  string       cur_req = "R1";
  logic [31:0] exp_rd = 32'd0;
  bit          rd_valid = 0;

  task automatic chk(string f, logic [31:0] a, logic [31:0] e);
    vectors++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", cur_req, f, a, e);
    end
  endtask

  task automatic tick();
    ent_t e;
    bit   busy;
    logic ece;
    @(negedge clk);
    busy = (q.size() != 0);
    if (busy) e = q.pop_front();
    else begin
      e = '0; e.we_n = 1'b1; e.re_n = 1'b1; e.din = 16'hDEAD;
    end
    nand_dq_in = e.din;
    ece = !(e.ce_on && cfg_ctrl[2]);
    chk("ce_n", {31'd0, nand_ce_n}, {31'd0, ece});
    chk("cle",  {31'd0, nand_cle},  {31'd0, e.cle});
    chk("ale",  {31'd0, nand_ale},  {31'd0, e.ale});
    chk("we_n", {31'd0, nand_we_n}, {31'd0, e.we_n});
    chk("re_n", {31'd0, nand_re_n}, {31'd0, e.re_n});
    chk("dq_oe",{31'd0, nand_dq_oe},{31'd0, e.oe});
    chk("rdy",  {31'd0, host_rdy},  {31'd0, !busy});
    if (e.oe) chk("dq", {16'd0, nand_dq_out}, {16'd0, e.dq});
    if (!busy && rd_valid) chk("rdata", host_rdata, exp_rd);
  endtask

  task automatic push(logic ce_on, logic cle, logic ale, logic we_n, logic re_n,
                      logic oe, logic [15:0] dq, logic [15:0] din, int n);
    ent_t e;
    e.ce_on = ce_on; e.cle = cle; e.ale = ale; e.we_n = we_n; e.re_n = re_n;
    e.oe = oe; e.dq = dq; e.din = din;
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic acc(logic [1:0] tgt, logic we, logic word, logic [31:0] wd);
    int s, w, h, z, d, nb;
    bit data, wr, b16, isc, isa;
    logic [31:0] rdv;
    logic [15:0] dqv, din;
    while (q.size() != 0) tick();
    tick();
    s = cfg_timing[7:0];
    w = (cfg_timing[15:8] == 0) ? 1 : int'(cfg_timing[15:8]);
    h = (cfg_timing[23:16] == 0) ? 1 : int'(cfg_timing[23:16]);
    z = cfg_timing[31:24];
    b16 = cfg_ctrl[4];
    data = tgt[1];
    isc = (tgt == 2'b00);
    isa = (tgt == 2'b01);
    wr = !data || we;
    d = 0;
    if (data && !we) d = (prev_m == 1) ? int'(cfg_ctrl[12:9]) : (prev_m == 2) ? int'(cfg_ctrl[16:13]) : 0;
    prev_m = data ? 0 : (tgt[0] ? 2 : 1);
    nb = (data && word) ? (b16 ? 2 : 4) : 1;
    push(1, 0, 0, 1, 1, 0, 16'd0, 16'hDEAD, d);
    rdv = 32'd0;
    seqno++;
    for (int k = 0; k < nb; k++) begin
      if (!(data && word)) dqv = {8'd0, wd[7:0]};
      else if (b16)        dqv = wd[16*k +: 16];
      else                 dqv = {8'd0, wd[8*k +: 8]};
      din = 16'h3C00 + 16'(k * 16'h0111) + 16'(seqno * 16'h0025);
      if (!(data && word)) rdv = {24'd0, din[7:0]};
      else if (b16)        rdv[16*k +: 16] = din;
      else                 rdv[8*k +: 8] = din[7:0];
      push(1, isc, isa, 1, 1, wr, dqv, 16'hDEAD, s);
      push(1, isc, isa, !wr, wr, wr, dqv, din, w);
      push(1, isc, isa, 1, 1, wr, dqv, 16'hDEAD, h);
      push(0, 0, 0, 1, 1, 0, 16'd0, 16'hDEAD, z);
    end
    if (!wr) begin
      exp_rd = rdv;
      rd_valid = 1;
    end
    host_tgt = tgt; host_we = we; host_word = word; host_wdata = wd;
    host_req = 1'b1;
    tick();
    host_req = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) tick();
    tick();
  endtask

  initial begin
    cfg_ctrl   = 32'h4 | (32'd3 << 9) | (32'd2 << 13);
    cfg_timing = 32'h01_01_02_01;
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();

    cur_req = "R5"; acc(2'b00, 1'b0, 1'b0, 32'h0000_0070);
    cur_req = "R9"; acc(2'b10, 1'b0, 1'b1, 32'd0);
    cur_req = "R7"; drain();
    cur_req = "R5"; acc(2'b01, 1'b0, 1'b0, 32'h0000_00A5);
    cur_req = "R9"; acc(2'b11, 1'b0, 1'b0, 32'd0);
    cur_req = "R7"; drain();
    cur_req = "R6"; acc(2'b10, 1'b1, 1'b1, 32'hA1B2_C3D4);
    cur_req = "R8"; acc(2'b10, 1'b0, 1'b1, 32'd0);
    cur_req = "R7"; drain();

    cur_req = "R4"; cfg_timing = 32'h0;
    acc(2'b00, 1'b1, 1'b0, 32'h0000_0090);
    acc(2'b10, 1'b0, 1'b1, 32'd0);
    acc(2'b10, 1'b1, 1'b0, 32'h0000_005E);
    drain();

    cur_req = "R8"; cfg_ctrl[4] = 1'b1; cfg_timing = 32'h02_03_04_02;
    acc(2'b10, 1'b1, 1'b1, 32'h1234_5678);
    acc(2'b10, 1'b0, 1'b1, 32'd0);
    acc(2'b10, 1'b0, 1'b0, 32'd0);
    acc(2'b10, 1'b1, 1'b0, 32'hFFFF_FF3C);
    drain();
    cur_req = "R3"; acc(2'b01, 1'b1, 1'b0, 32'h0000_0011);
    drain();

    cur_req = "R10"; cfg_ctrl[2] = 1'b0;
    acc(2'b00, 1'b1, 1'b0, 32'h0000_00FF);
    drain();
    cfg_ctrl[2] = 1'b1;
    acc(2'b10, 1'b1, 1'b1, 32'hCAFE_F00D);
    tick(); cfg_ctrl[2] = 1'b0;
    repeat (3) tick();
    cfg_ctrl[2] = 1'b1;
    drain();

    cur_req = "R2"; cfg_timing = 32'h01_01_05_01;
    acc(2'b10, 1'b1, 1'b1, 32'h0BAD_BEEF);
    tick();
    host_tgt = 2'b00; host_wdata = 32'h0000_00EE; host_req = 1'b1;
    repeat (3) tick();
    host_req = 1'b0;
    drain();

    cur_req = "R11"; cfg_ctrl = cfg_ctrl | 32'hFFFE_01EB; cfg_ctrl[4] = 1'b0;
    acc(2'b00, 1'b1, 1'b0, 32'h0000_0030);
    acc(2'b10, 1'b0, 1'b1, 32'd0);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired: got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule